// File: doc/BRIEF.md
# Paired Store and Checkpoint Validation Queue

Two cores run the same program in lockstep at different speeds: a fast leader that may run ahead, and a slower checker that trails it. Neither core writes the shared next-level cache directly. Every write-through store from the leader is parked in a small queue. The store is released on a valid/ready write port only after the checker has produced the store with the same ordinal, and the two copies agree in address, data and byte enables. Any disagreement raises a sticky error flag. On that error the queue discards all leader stores that have not yet been paired, and accepts no further stores or hashes until software or a recovery sequencer pulses a clear input.

At intervals of a fixed number of retired instructions, each core also reports a hash of its register checkpoint. Leader hashes wait in a second queue until the checker's hash with the same ordinal arrives. A pair that agrees becomes a candidate. The candidate is promoted to "last verified" only once every store that the leader issued before that hash has been paired and written out. The last verified checkpoint (its ordinal, its hash and its instruction count) stays on the outputs, so that both register files can be restored from it after an error.

Top module: `store_pair_validator`

## Requirements
- R1: After reset, err=0, fwd_valid=0, vfy_valid=0, ld_st_ready=1 and ld_hash_ready=1. A leader store is never presented on the forward port before the checker store paired with it has been accepted.
- R2: The k-th store accepted from the leader pairs with the k-th checker store. When address, data and byte enables are all equal, the entry becomes forwardable one cycle after the checker store is sampled. Entries leave the forward port in leader order.
- R3: A paired checker store that differs in address, data or byte enables sets err one cycle later. That entry and every other unpaired leader entry are discarded and never forwarded.
- R4: A checker store sampled while no unpaired leader entry is held (leader stores accepted in that same cycle do not count) sets err one cycle later.
- R5: The queue holds at most DEPTH leader entries, paired or not, until each is written out. With DEPTH entries held, ld_st_ready is 0. The checker store input has no back-pressure.
- R6: An entry leaves the forward port only in a cycle with fwd_valid=1 and fwd_ready=1. While fwd_ready is 0, fwd_valid, fwd_addr, fwd_data and fwd_be hold their values.
- R7: err stays 1 until a cycle in which clr_err=1 and no new mismatch occurs. While err=1, ld_st_ready=0 and ld_hash_ready=0, and store and hash inputs from both cores are ignored.
- R8: The k-th leader hash pairs with the k-th checker hash. Unequal hashes, or a checker hash with no leader hash pending, set err one cycle later.
- R9: A matched hash pair becomes the verified checkpoint (vfy_valid=1, vfy_idx = its leader ordinal counted from 0, vfy_hash, vfy_insn = (vfy_idx+1)*CKPT_N) only after every leader store accepted before that hash's cycle has been written out. With those stores already written out, the outputs update two cycles after the checker hash is sampled.
- R10: An error keeps the verified checkpoint, discards pending hashes and any candidate, and numbers the next leader hash vfy_idx+1 (or 0 if none has been verified).
- R11: With HQ_DEPTH leader hashes pending, ld_hash_ready is 0. It returns to 1 the cycle after a checker hash consumes one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr_err | input | 1 | Pulse to clear the error flag |
| ld_st_valid | input | 1 | Leader store valid |
| ld_st_ready | output | 1 | Queue accepts a leader store |
| ld_st_addr | input | ADDR_W | Leader store address |
| ld_st_data | input | DATA_W | Leader store data |
| ld_st_be | input | DATA_W/8 | Leader store byte enables |
| ck_st_valid | input | 1 | Checker store valid (no ready) |
| ck_st_addr | input | ADDR_W | Checker store address |
| ck_st_data | input | DATA_W | Checker store data |
| ck_st_be | input | DATA_W/8 | Checker store byte enables |
| ld_hash_valid | input | 1 | Leader checkpoint hash valid |
| ld_hash_ready | output | 1 | Queue accepts a leader hash |
| ld_hash | input | HASH_W | Leader checkpoint hash |
| ck_hash_valid | input | 1 | Checker checkpoint hash valid |
| ck_hash | input | HASH_W | Checker checkpoint hash |
| fwd_valid | output | 1 | Verified store available for the cache |
| fwd_ready | input | 1 | Cache takes the store |
| fwd_addr | output | ADDR_W | Verified store address |
| fwd_data | output | DATA_W | Verified store data |
| fwd_be | output | DATA_W/8 | Verified store byte enables |
| err | output | 1 | Sticky mismatch flag |
| vfy_valid | output | 1 | A verified checkpoint exists |
| vfy_idx | output | IDX_W | Ordinal of the verified checkpoint |
| vfy_hash | output | HASH_W | Hash of the verified checkpoint |
| vfy_insn | output | INSN_W | Instruction count at the verified checkpoint |

## Verification
The bound assertions check, on every cycle, the properties that are local in time. The occupancy never exceeds DEPTH, and a full queue refuses leader stores. A stalled forward port holds its contents. Any detected mismatch raises the flag on the next cycle. The flag stays set until it is cleared and blocks both leader inputs while it is set. Once a verified checkpoint exists, it is never lost.

Other properties depend on the history of the stimulus, so only the bench scenarios can show them. These are the pairing order across several buffered stores, the discarding of unpaired entries (seen as a later checker store being reported as an orphan), the delay of promotion until earlier stores have drained, and the checkpoint numbering that resumes after an error.

// File: rtl/svq_pkg.sv
package svq_pkg;

  // outcome of comparing one checker item against the leader's queue head
  typedef enum logic [1:0] {
    CMP_IDLE   = 2'd0,
    CMP_MATCH  = 2'd1,
    CMP_DIFF   = 2'd2,
    CMP_ORPHAN = 2'd3
  } cmp_res_t;

  function automatic logic is_bad(input cmp_res_t r);
    return (r == CMP_DIFF) || (r == CMP_ORPHAN);
  endfunction

endpackage

// File: rtl/svq_store_buf.sv
module svq_store_buf
  import svq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BE_W   = 4,
  parameter int DEPTH  = 4,
  parameter int SEQ_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt,
  input  logic              flush,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [BE_W-1:0]   ld_be,
  input  logic              ck_valid,
  input  logic [ADDR_W-1:0] ck_addr,
  input  logic [DATA_W-1:0] ck_data,
  input  logic [BE_W-1:0]   ck_be,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_data,
  output logic [BE_W-1:0]   fwd_be,
  output cmp_res_t          cmp_res,
  output logic [SEQ_W-1:0]  wr_cnt,
  output logic [SEQ_W-1:0]  rd_cnt,
  output logic [SEQ_W-1:0]  occ
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int ENT_W = ADDR_W + DATA_W + BE_W;
  localparam logic [SEQ_W-1:0] FULL_S = SEQ_W'(DEPTH);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [SEQ_W-1:0] cmp_cnt, cmp_nxt;
  logic [ENT_W-1:0] head, ck_ent, out_ent;
  logic push, pop, pending, ck_fire;

  assign occ      = wr_cnt - rd_cnt;
  assign pending  = (wr_cnt != cmp_cnt);
  assign ld_ready = !halt && (occ < FULL_S);
  assign push     = ld_valid && ld_ready;
  assign ck_fire  = ck_valid && !halt;
  assign head     = mem[cmp_cnt[PTR_W-1:0]];
  assign ck_ent   = {ck_addr, ck_data, ck_be};

  always_comb begin
    if (!ck_fire)           cmp_res = CMP_IDLE;
    else if (!pending)      cmp_res = CMP_ORPHAN;
    else if (head == ck_ent) cmp_res = CMP_MATCH;
    else                    cmp_res = CMP_DIFF;
  end

  assign cmp_nxt   = (cmp_res == CMP_MATCH) ? cmp_cnt + 1'b1 : cmp_cnt;
  assign fwd_valid = (rd_cnt != cmp_cnt);
  assign pop       = fwd_valid && fwd_ready;
  assign out_ent   = mem[rd_cnt[PTR_W-1:0]];
  assign fwd_addr  = out_ent[ENT_W-1 -: ADDR_W];
  assign fwd_data  = out_ent[BE_W +: DATA_W];
  assign fwd_be    = out_ent[BE_W-1:0];

  always_ff @(posedge clk) begin
    if (push) mem[wr_cnt[PTR_W-1:0]] <= {ld_addr, ld_data, ld_be};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_cnt  <= '0;
      rd_cnt  <= '0;
      cmp_cnt <= '0;
    end else begin
      cmp_cnt <= cmp_nxt;
      if (pop) rd_cnt <= rd_cnt + 1'b1;
      if (flush)     wr_cnt <= cmp_nxt;   // drop every unpaired entry
      else if (push) wr_cnt <= wr_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/svq_ckpt.sv
module svq_ckpt
  import svq_pkg::*;
#(
  parameter int HASH_W   = 32,
  parameter int HQ_DEPTH = 4,
  parameter int SEQ_W    = 16,
  parameter int IDX_W    = 8,
  parameter int CKPT_N   = 64,
  parameter int INSN_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt,
  input  logic              flush,
  input  logic              ld_hv,
  output logic              ld_hready,
  input  logic [HASH_W-1:0] ld_hash,
  input  logic              ck_hv,
  input  logic [HASH_W-1:0] ck_hash,
  input  logic [SEQ_W-1:0]  st_wr_cnt,
  input  logic [SEQ_W-1:0]  st_rd_cnt,
  output cmp_res_t          cmp_res,
  output logic              vfy_valid,
  output logic [IDX_W-1:0]  vfy_idx,
  output logic [HASH_W-1:0] vfy_hash,
  output logic [INSN_W-1:0] vfy_insn
);

  localparam int HQ_PTR_W = $clog2(HQ_DEPTH);
  localparam int HE_W     = HASH_W + SEQ_W + IDX_W;
  localparam logic [HQ_PTR_W:0] HQ_FULL = (HQ_PTR_W+1)'(HQ_DEPTH);

  // true once the drain counter has reached or passed a boundary (wrap-safe)
  function automatic logic seq_reached(input logic [SEQ_W-1:0] cur,
                                       input logic [SEQ_W-1:0] bnd);
    logic [SEQ_W-1:0] diff;
    diff = cur - bnd;
    return !diff[SEQ_W-1];
  endfunction

  function automatic logic [INSN_W-1:0] insn_at(input logic [IDX_W-1:0] idx);
    return INSN_W'((idx + 1) * CKPT_N);
  endfunction

  logic [HE_W-1:0] hq [HQ_DEPTH];
  logic [HQ_PTR_W:0] hq_wr, hq_rd, hq_cnt;
  logic [HE_W-1:0] head;
  logic [HASH_W-1:0] head_hash;
  logic [SEQ_W-1:0]  head_bnd;
  logic [IDX_W-1:0]  head_idx, next_idx, resume_idx;
  logic hpush, ck_fire, promote;
  logic              cand_valid;
  logic [HASH_W-1:0] cand_hash;
  logic [SEQ_W-1:0]  cand_bnd;
  logic [IDX_W-1:0]  cand_idx;

  assign hq_cnt    = hq_wr - hq_rd;
  assign ld_hready = !halt && (hq_cnt < HQ_FULL);
  assign hpush     = ld_hv && ld_hready;
  assign ck_fire   = ck_hv && !halt;
  assign head      = hq[hq_rd[HQ_PTR_W-1:0]];
  assign head_hash = head[HE_W-1 -: HASH_W];
  assign head_bnd  = head[IDX_W +: SEQ_W];
  assign head_idx  = head[IDX_W-1:0];

  always_comb begin
    if (!ck_fire)                cmp_res = CMP_IDLE;
    else if (hq_cnt == '0)       cmp_res = CMP_ORPHAN;
    else if (head_hash == ck_hash) cmp_res = CMP_MATCH;
    else                         cmp_res = CMP_DIFF;
  end

  assign promote    = cand_valid && seq_reached(st_rd_cnt, cand_bnd);
  assign resume_idx = promote ? cand_idx + 1'b1 :
                      (vfy_valid ? vfy_idx + 1'b1 : '0);
  assign vfy_insn   = insn_at(vfy_idx);

  always_ff @(posedge clk) begin
    if (hpush) hq[hq_wr[HQ_PTR_W-1:0]] <= {ld_hash, st_wr_cnt, next_idx};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hq_wr      <= '0;
      hq_rd      <= '0;
      next_idx   <= '0;
      cand_valid <= 1'b0;
      cand_hash  <= '0;
      cand_bnd   <= '0;
      cand_idx   <= '0;
      vfy_valid  <= 1'b0;
      vfy_idx    <= '0;
      vfy_hash   <= '0;
    end else begin
      if (hpush) begin
        hq_wr    <= hq_wr + 1'b1;
        next_idx <= next_idx + 1'b1;
      end
      if (cmp_res == CMP_MATCH || cmp_res == CMP_DIFF) hq_rd <= hq_rd + 1'b1;
      if (promote) begin
        vfy_valid  <= 1'b1;
        vfy_idx    <= cand_idx;
        vfy_hash   <= cand_hash;
        cand_valid <= 1'b0;
      end
      if (cmp_res == CMP_MATCH) begin
        cand_valid <= 1'b1;
        cand_hash  <= head_hash;
        cand_bnd   <= head_bnd;
        cand_idx   <= head_idx;
      end
      if (flush) begin
        hq_wr      <= '0;
        hq_rd      <= '0;
        cand_valid <= 1'b0;
        next_idx   <= resume_idx;
      end
    end
  end

endmodule

// File: rtl/store_pair_validator.sv
module store_pair_validator
  import svq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int DEPTH    = 4,
  parameter int HQ_DEPTH = 4,
  parameter int HASH_W   = 32,
  parameter int SEQ_W    = 16,
  parameter int IDX_W    = 8,
  parameter int CKPT_N   = 64,
  parameter int INSN_W   = 32,
  localparam int BE_W    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_err,
  input  logic              ld_st_valid,
  output logic              ld_st_ready,
  input  logic [ADDR_W-1:0] ld_st_addr,
  input  logic [DATA_W-1:0] ld_st_data,
  input  logic [BE_W-1:0]   ld_st_be,
  input  logic              ck_st_valid,
  input  logic [ADDR_W-1:0] ck_st_addr,
  input  logic [DATA_W-1:0] ck_st_data,
  input  logic [BE_W-1:0]   ck_st_be,
  input  logic              ld_hash_valid,
  output logic              ld_hash_ready,
  input  logic [HASH_W-1:0] ld_hash,
  input  logic              ck_hash_valid,
  input  logic [HASH_W-1:0] ck_hash,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_data,
  output logic [BE_W-1:0]   fwd_be,
  output logic              err,
  output logic              vfy_valid,
  output logic [IDX_W-1:0]  vfy_idx,
  output logic [HASH_W-1:0] vfy_hash,
  output logic [INSN_W-1:0] vfy_insn
);

  cmp_res_t         st_res, h_res;
  logic             store_bad, hash_bad, flush;
  logic [SEQ_W-1:0] st_wr_cnt, st_rd_cnt, occ;

  assign store_bad = is_bad(st_res);
  assign hash_bad  = is_bad(h_res);
  assign flush     = store_bad || hash_bad;

  svq_store_buf #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W), .DEPTH(DEPTH), .SEQ_W(SEQ_W)
  ) u_st (
    .clk(clk), .rst_n(rst_n), .halt(err), .flush(flush),
    .ld_valid(ld_st_valid), .ld_ready(ld_st_ready),
    .ld_addr(ld_st_addr), .ld_data(ld_st_data), .ld_be(ld_st_be),
    .ck_valid(ck_st_valid), .ck_addr(ck_st_addr), .ck_data(ck_st_data), .ck_be(ck_st_be),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready),
    .fwd_addr(fwd_addr), .fwd_data(fwd_data), .fwd_be(fwd_be),
    .cmp_res(st_res), .wr_cnt(st_wr_cnt), .rd_cnt(st_rd_cnt), .occ(occ)
  );

  svq_ckpt #(
    .HASH_W(HASH_W), .HQ_DEPTH(HQ_DEPTH), .SEQ_W(SEQ_W), .IDX_W(IDX_W),
    .CKPT_N(CKPT_N), .INSN_W(INSN_W)
  ) u_ck (
    .clk(clk), .rst_n(rst_n), .halt(err), .flush(flush),
    .ld_hv(ld_hash_valid), .ld_hready(ld_hash_ready), .ld_hash(ld_hash),
    .ck_hv(ck_hash_valid), .ck_hash(ck_hash),
    .st_wr_cnt(st_wr_cnt), .st_rd_cnt(st_rd_cnt),
    .cmp_res(h_res), .vfy_valid(vfy_valid), .vfy_idx(vfy_idx),
    .vfy_hash(vfy_hash), .vfy_insn(vfy_insn)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       err <= 1'b0;
    else if (flush)   err <= 1'b1;
    else if (clr_err) err <= 1'b0;
  end

endmodule

// File: rtl/svq_checker.sv
module svq_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BE_W   = 4,
  parameter int DEPTH  = 4,
  parameter int SEQ_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_err,
  input logic              err,
  input logic              ld_st_ready,
  input logic              ld_hash_ready,
  input logic              fwd_valid,
  input logic              fwd_ready,
  input logic [ADDR_W-1:0] fwd_addr,
  input logic [DATA_W-1:0] fwd_data,
  input logic [BE_W-1:0]   fwd_be,
  input logic              store_bad,
  input logic              hash_bad,
  input logic [SEQ_W-1:0]  occ,
  input logic              vfy_valid
);

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= SEQ_W'(DEPTH));

  a_r5_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == SEQ_W'(DEPTH)) |-> !ld_st_ready);

  a_r6_fwd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && !fwd_ready) |=>
      (fwd_valid && $stable(fwd_addr) && $stable(fwd_data) && $stable(fwd_be)));

  a_r3_mismatch_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (store_bad || hash_bad) |=> err);

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clr_err) |=> err);

  a_r7_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!ld_st_ready && !ld_hash_ready));

  a_r10_vfy_kept: assert property (@(posedge clk) disable iff (!rst_n)
    vfy_valid |=> vfy_valid);

endmodule

bind store_pair_validator svq_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W), .DEPTH(DEPTH), .SEQ_W(SEQ_W)
) u_svq_chk (
  .clk(clk), .rst_n(rst_n), .clr_err(clr_err), .err(err),
  .ld_st_ready(ld_st_ready), .ld_hash_ready(ld_hash_ready),
  .fwd_valid(fwd_valid), .fwd_ready(fwd_ready),
  .fwd_addr(fwd_addr), .fwd_data(fwd_data), .fwd_be(fwd_be),
  .store_bad(store_bad), .hash_bad(hash_bad), .occ(occ), .vfy_valid(vfy_valid)
);

// File: tb/store_pair_validator_test.sv
module store_pair_validator_test;

  localparam int AW = 32, DW = 32, BW = 4, HW = 32, IW = 8, NW = 32;
  localparam int DEPTH = 4, HQ_DEPTH = 4, CKPT_N = 64;

  logic clk = 1'b0;
  logic rst_n, clr_err;
  logic ld_st_valid, ld_st_ready, ck_st_valid;
  logic [AW-1:0] ld_st_addr, ck_st_addr, fwd_addr;
  logic [DW-1:0] ld_st_data, ck_st_data, fwd_data;
  logic [BW-1:0] ld_st_be, ck_st_be, fwd_be;
  logic ld_hash_valid, ld_hash_ready, ck_hash_valid;
  logic [HW-1:0] ld_hash, ck_hash, vfy_hash;
  logic fwd_valid, fwd_ready, err, vfy_valid;
  logic [IW-1:0] vfy_idx;
  logic [NW-1:0] vfy_insn;

  int n_checks = 0, n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  store_pair_validator #(.DEPTH(DEPTH), .HQ_DEPTH(HQ_DEPTH), .CKPT_N(CKPT_N)) uut (
    .clk(clk), .rst_n(rst_n), .clr_err(clr_err),
    .ld_st_valid(ld_st_valid), .ld_st_ready(ld_st_ready),
    .ld_st_addr(ld_st_addr), .ld_st_data(ld_st_data), .ld_st_be(ld_st_be),
    .ck_st_valid(ck_st_valid), .ck_st_addr(ck_st_addr), .ck_st_data(ck_st_data),
    .ck_st_be(ck_st_be),
    .ld_hash_valid(ld_hash_valid), .ld_hash_ready(ld_hash_ready), .ld_hash(ld_hash),
    .ck_hash_valid(ck_hash_valid), .ck_hash(ck_hash),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready),
    .fwd_addr(fwd_addr), .fwd_data(fwd_data), .fwd_be(fwd_be),
    .err(err), .vfy_valid(vfy_valid), .vfy_idx(vfy_idx), .vfy_hash(vfy_hash),
    .vfy_insn(vfy_insn)
  );

  // {addr, data, be, perturbation kind}; kind 0 = identical, 1 = data, 2 = addr, 3 = be
  localparam logic [69:0] VEC [6] = '{
    {32'h0000_1000, 32'hDEAD_BEEF, 4'hF, 2'd0},
    {32'h0000_2004, 32'h0123_4567, 4'h3, 2'd0},
    {32'h0000_3008, 32'hA5A5_5A5A, 4'hF, 2'd1},
    {32'h0000_400C, 32'h1111_2222, 4'hC, 2'd2},
    {32'h0000_5010, 32'h3333_4444, 4'h1, 2'd3},
    {32'h0000_6014, 32'hFFFF_0000, 4'h6, 2'd0}
  };

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    clr_err = 0; ld_st_valid = 0; ck_st_valid = 0; ld_hash_valid = 0; ck_hash_valid = 0;
    ld_st_addr = '0; ld_st_data = '0; ld_st_be = '0;
    ck_st_addr = '0; ck_st_data = '0; ck_st_be = '0;
    ld_hash = '0; ck_hash = '0; fwd_ready = 1;
  endtask

  task automatic do_reset();
    @(negedge clk); idle_inputs(); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    @(negedge clk);
  endtask

  task automatic ld_store(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [BW-1:0] b);
    ld_st_valid = 1; ld_st_addr = a; ld_st_data = d; ld_st_be = b;
    @(negedge clk); ld_st_valid = 0;
  endtask

  task automatic ck_store(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [BW-1:0] b);
    ck_st_valid = 1; ck_st_addr = a; ck_st_data = d; ck_st_be = b;
    @(negedge clk); ck_st_valid = 0;
  endtask

  task automatic ld_hput(input logic [HW-1:0] h);
    ld_hash_valid = 1; ld_hash = h; @(negedge clk); ld_hash_valid = 0;
  endtask

  task automatic ck_hput(input logic [HW-1:0] h);
    ck_hash_valid = 1; ck_hash = h; @(negedge clk); ck_hash_valid = 0;
  endtask

  task automatic clear_err();
    clr_err = 1; @(negedge clk); clr_err = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [AW-1:0] oa [3];
    rst_n = 0; idle_inputs();
    do_reset();

    // R1: reset state
    chk(!err, "R1 err after reset", err, 0);
    chk(!fwd_valid, "R1 fwd_valid after reset", fwd_valid, 0);
    chk(!vfy_valid, "R1 vfy_valid after reset", vfy_valid, 0);
    chk(ld_st_ready && ld_hash_ready, "R1 readies after reset",
        {ld_st_ready, ld_hash_ready}, 2'b11);

    // vector table: R2 match path, R3 mismatch in data/addr/be
    for (int i = 0; i < 6; i++) begin
      logic [AW-1:0] a; logic [DW-1:0] d; logic [BW-1:0] b; logic [1:0] k;
      a = VEC[i][69:38]; d = VEC[i][37:6]; b = VEC[i][5:2]; k = VEC[i][1:0];
      ld_store(a, d, b);
      chk(!fwd_valid, "R1 held before checker", fwd_valid, 0);
      ck_store(k == 2 ? a ^ 32'h4 : a, k == 1 ? d ^ 32'h100 : d, k == 3 ? b ^ 4'h1 : b);
      if (k == 0) begin
        chk(fwd_valid && fwd_addr == a && fwd_data == d && fwd_be == b,
            "R2 paired store forwarded", {fwd_valid, fwd_addr}, {1'b1, a});
        @(negedge clk);
        chk(!fwd_valid, "R6 popped after handshake", fwd_valid, 0);
      end else begin
        chk(err, "R3 mismatch raises err", err, 1);
        chk(!fwd_valid, "R3 mismatched store not forwarded", fwd_valid, 0);
        clear_err();
        chk(!err, "R7 clr_err clears", err, 0);
      end
    end

    // R2/R6: order preservation with a stalled forward port
    do_reset();
    fwd_ready = 0;
    for (int i = 0; i < 3; i++) begin
      oa[i] = 32'h100 + 32'(i) * 4;
      ld_store(oa[i], 32'hC0DE_0000 + 32'(i), 4'hF);
    end
    chk(!fwd_valid, "R1 nothing forwarded before checker", fwd_valid, 0);
    for (int i = 0; i < 3; i++) ck_store(oa[i], 32'hC0DE_0000 + 32'(i), 4'hF);
    @(negedge clk); @(negedge clk);
    chk(fwd_valid && fwd_addr == oa[0], "R6 stalled head held", fwd_addr, oa[0]);
    fwd_ready = 1;
    for (int i = 0; i < 3; i++) begin
      chk(fwd_valid && fwd_addr == oa[i] && fwd_data == 32'hC0DE_0000 + 32'(i),
          "R2 order preserved", fwd_addr, oa[i]);
      @(negedge clk);
    end
    chk(!fwd_valid, "R6 queue drained", fwd_valid, 0);

    // R5: full queue, then R3 flush seen through R4 orphan
    do_reset();
    for (int i = 0; i < DEPTH; i++) ld_store(32'h200 + 32'(i), 32'(i), 4'hF);
    chk(!ld_st_ready, "R5 full deasserts ready", ld_st_ready, 0);
    ck_store(32'h200, 32'd0, 4'hF);
    chk(fwd_valid && !ld_st_ready, "R5 still full until drained", ld_st_ready, 0);
    @(negedge clk);
    chk(ld_st_ready, "R5 ready after drain", ld_st_ready, 1);
    ck_store(32'h201, 32'd99, 4'hF);
    chk(err, "R3 data mismatch err", err, 1);
    clear_err();
    ck_store(32'h202, 32'd2, 4'hF);
    chk(err, "R3 unpaired entries flushed (later store is orphan)", err, 1);
    chk(!fwd_valid, "R3 flushed entries not forwarded", fwd_valid, 0);

    // R4 orphan, R7 inputs ignored while err
    do_reset();
    ck_store(32'h300, 32'd7, 4'hF);
    chk(err, "R4 orphan checker store", err, 1);
    chk(!ld_st_ready && !ld_hash_ready, "R7 readies low in err",
        {ld_st_ready, ld_hash_ready}, 0);
    ld_store(32'h300, 32'd7, 4'hF);
    @(negedge clk);
    chk(err, "R7 err sticky", err, 1);
    clear_err();
    ck_store(32'h300, 32'd7, 4'hF);
    chk(err, "R7 leader store during err ignored", err, 1);

    // R9/R10/R8 checkpoint path
    do_reset();
    fwd_ready = 0;
    ld_store(32'h400, 32'h55, 4'hF);
    ld_hput(32'hABCD_0001);
    ck_store(32'h400, 32'h55, 4'hF);
    ck_hput(32'hABCD_0001);
    repeat (3) @(negedge clk);
    chk(!vfy_valid, "R9 not promoted before drain", vfy_valid, 0);
    fwd_ready = 1; @(negedge clk); fwd_ready = 0;
    @(negedge clk);
    chk(vfy_valid && vfy_idx == 0 && vfy_hash == 32'hABCD_0001,
        "R9 promoted after drain", {vfy_valid, vfy_idx}, {1'b1, 8'd0});
    chk(vfy_insn == NW'(CKPT_N), "R9 instruction count", vfy_insn, CKPT_N);
    fwd_ready = 1;
    ld_hput(32'hABCD_0002);
    ck_hput(32'hABCD_0003);
    chk(err, "R8 hash mismatch err", err, 1);
    chk(vfy_valid && vfy_idx == 0, "R10 verified kept", vfy_idx, 0);
    clear_err();
    ld_hput(32'hABCD_0004);
    ck_hput(32'hABCD_0004);
    @(negedge clk);
    chk(vfy_idx == 1 && vfy_hash == 32'hABCD_0004, "R10 index resumes", vfy_idx, 1);
    chk(vfy_insn == NW'(2 * CKPT_N), "R9 instruction count second", vfy_insn, 2 * CKPT_N);
    ck_hput(32'hABCD_0005);
    chk(err, "R8 orphan hash err", err, 1);

    // R11 hash queue full
    do_reset();
    for (int i = 0; i < HQ_DEPTH; i++) ld_hput(32'h9000 + 32'(i));
    chk(!ld_hash_ready, "R11 hash queue full", ld_hash_ready, 0);
    ck_hput(32'h9000);
    chk(ld_hash_ready && !err, "R11 ready after pop", {ld_hash_ready, err}, 2'b10);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule